// File: doc/BRIEF.md
# Shared Interrupt Source Router

This block collects a parameterised set of level-sensitive interrupt sources and routes each one to an interrupt line of a virtual processor (VP). Each source has four pieces of state: a pending bit, an enable bit, a pin number and an optional VP assignment. The block drives one output line for every (VP, pin) pair. That line is the OR of all sources that are enabled, pending and routed to that pair. The first `PIN_OFS` lines of each VP are reserved and always stay low, so pin `p` of VP `v` appears on `cpu_irq[v*(NUM_PIN+PIN_OFS) + p + PIN_OFS]`.

Software reaches the block through a 32-bit register port with byte addresses. A write takes effect in the cycle in which it is presented. A read returns data combinationally for the presented address. The register set is:
- a configuration word;
- a wedge register, which lets software force a source's pending level;
- bitmaps that read pending and enable state;
- bitmaps that set or clear enables, one bit per source;
- one pin-map word for each source;
- one 32-byte VP-map slot for each source.

Address decode is done by an enumerated region type with one name per register group: `RG_NONE`, `RG_CONFIG`, `RG_WEDGE`, `RG_PEND`, `RG_MASK`, `RG_SETM`, `RG_CLRM`, `RG_PINMAP`, `RG_VPMAP`. The block has no sequential controller. Every access completes in one cycle.

Top module: `irq_source_router`

## Requirements
- R1: After reset every source is disabled, not pending and unassigned to any VP, with pin 0. All `cpu_irq` lines are low. A pin-map word reads 0x80000000 and a VP-map slot reads 0.
- R2: Address 0x000 reads the configuration. Bits [15:8] hold NUM_SRC/8-1 and bits [7:0] hold NUM_VP. With the defaults the word is 0x00000302.
- R3: A source's pending bit takes the new input level at the rising edge after the input changes. The pending bitmap at 0x100 shows it from then on, whether or not the source is enabled.
- R4: The line for pin p of VP v is high exactly when at least one source is enabled, pending, assigned to VP v and mapped to pin p. The line settles one cycle after the triggering write or input change. Lines 0 and 1 of each VP stay low.
- R5: A write to the set bitmap at 0x140 enables every source whose data bit is 1. A write to the clear bitmap at 0x160 disables every source whose data bit is 1. Zero bits leave the enable unchanged. The enable bitmap reads at 0x120.
- R6: The bitmap regions are byte addressed. Offset o from the region base covers sources 8o to 8o+31. An access with 8o+32 greater than NUM_SRC is ignored on write and reads 0.
- R7: A write to the wedge register at 0x004 sets the pending bit of the source indexed by bits [30:0] to the level in bit 31. An index at or beyond NUM_SRC is ignored. For a source named by a wedge write, the wedge level wins over an input change in the same cycle.
- R8: The pin-map word for source s sits at 0x400+4s and holds the pin in bits [5:0]. A read returns bit 31 set together with the pin. A write whose pin exceeds NUM_PIN-1 is rejected and the old value is kept.
- R9: The VP-map slot for source s covers 0x800+32s to 0x800+32s+31. Writing 0 unassigns the source. Otherwise the lowest set bit selects the VP, and a VP at or beyond NUM_VP is rejected. A read returns 1 shifted left by the VP, or 0 when the source is unassigned.
- R10: Addresses outside every region read 0, as do map words of a source at or beyond NUM_SRC and the wedge register. Writes to those addresses change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| src_in | input | NUM_SRC | Level of each external interrupt source |
| bus_addr | input | 14 | Byte address of the register access |
| bus_we | input | 1 | Write strobe for the presented address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for the presented address |
| cpu_irq | output | NUM_VP*(NUM_PIN+PIN_OFS) | Registered interrupt lines, grouped per VP |

## Verification
Two cases need careful stimulus: a shared line whose sources drop one at a time, and a single source that loses its VP assignment while it is still active. For the first, the bench routes two sources to the same VP and pin, then releases or disables them in turn. The line must stay high until the last contributor is gone. For the second, the bench raises a source through the wedge register, so the pending state does not depend on the input pins, and then rewrites that source's VP slot with 0. This shows that the line follows the assignment table and not only the enable bit. The rejection paths are checked at the ports as well. An out-of-range pin, a VP at or beyond the count, a bitmap offset that runs past the last source and a wedge index beyond the count are each followed by a readback of the state the write could have changed.

// File: rtl/irq_route_pkg.sv
package irq_route_pkg;

    localparam int ADDR_W  = 14;
    localparam int MAX_SRC = 256;

    localparam logic [ADDR_W-1:0] A_CONFIG = 14'h000;
    localparam logic [ADDR_W-1:0] A_WEDGE  = 14'h004;
    localparam logic [ADDR_W-1:0] A_PEND   = 14'h100;
    localparam logic [ADDR_W-1:0] A_MASK   = 14'h120;
    localparam logic [ADDR_W-1:0] A_SETM   = 14'h140;
    localparam logic [ADDR_W-1:0] A_CLRM   = 14'h160;
    localparam logic [ADDR_W-1:0] A_PINMAP = 14'h400;
    localparam logic [ADDR_W-1:0] A_VPMAP  = 14'h800;
    localparam logic [ADDR_W-1:0] A_VPEND  = 14'h2800;

    typedef enum logic [3:0] {
        RG_NONE, RG_CONFIG, RG_WEDGE, RG_PEND, RG_MASK,
        RG_SETM, RG_CLRM, RG_PINMAP, RG_VPMAP
    } region_e;

    function automatic logic [5:0] lowest_set(input logic [31:0] v);
        logic [5:0] r;
        r = 6'd0;
        for (int i = 31; i >= 0; i--) begin
            if (v[i]) r = 6'(i);
        end
        return r;
    endfunction

endpackage

// File: rtl/irq_src_bank.sv
module irq_src_bank #(
    parameter int NUM_SRC = 32,
    localparam int SW = $clog2(NUM_SRC)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [NUM_SRC-1:0] src_in,
    input  logic [NUM_SRC-1:0] set_vec,
    input  logic [NUM_SRC-1:0] clr_vec,
    input  logic               wedge_we,
    input  logic [SW-1:0]      wedge_idx,
    input  logic               wedge_lvl,
    output logic [NUM_SRC-1:0] en_q,
    output logic [NUM_SRC-1:0] pend_q,
    output logic [NUM_SRC-1:0] en_d,
    output logic [NUM_SRC-1:0] pend_d
);

    logic [NUM_SRC-1:0] src_prev;

    assign en_d = (en_q & ~clr_vec) | set_vec;

    for (genvar i = 0; i < NUM_SRC; i++) begin : g_pend
        always_comb begin
            if (wedge_we && int'(wedge_idx) == i)
                pend_d[i] = wedge_lvl;
            else if (src_in[i] != src_prev[i])
                pend_d[i] = src_in[i];
            else
                pend_d[i] = pend_q[i];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            en_q     <= '0;
            pend_q   <= '0;
            src_prev <= '0;
        end else begin
            en_q     <= en_d;
            pend_q   <= pend_d;
            src_prev <= src_in;
        end
    end

    // R5
    en_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((en_q & ~$past(en_q) & ~$past(set_vec)) == '0));

    // R5
    en_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((~en_q & $past(en_q) & ~$past(clr_vec)) == '0));

    // R3
    pend_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!$past(wedge_we) && $past(src_in) == $past(src_prev)) |-> $stable(pend_q));

    // R7
    wedge_apply_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wedge_we |=> (pend_q[$past(wedge_idx)] == $past(wedge_lvl)));

endmodule

// File: rtl/irq_map_bank.sv
module irq_map_bank #(
    parameter int NUM_SRC = 32,
    parameter int NUM_VP  = 2,
    parameter int NUM_PIN = 6,
    localparam int SW  = $clog2(NUM_SRC),
    localparam int VPW = (NUM_VP > 1) ? $clog2(NUM_VP) : 1,
    localparam int PW  = (NUM_PIN > 1) ? $clog2(NUM_PIN) : 1
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           pin_we,
    input  logic           vp_we,
    input  logic [SW-1:0]  idx,
    input  logic [PW-1:0]  pin_wval,
    input  logic           vp_wmap,
    input  logic [VPW-1:0] vp_wval,
    output logic [PW-1:0]  pin_q [NUM_SRC],
    output logic           map_q [NUM_SRC],
    output logic [VPW-1:0] vp_q  [NUM_SRC],
    output logic [PW-1:0]  pin_d [NUM_SRC],
    output logic           map_d [NUM_SRC],
    output logic [VPW-1:0] vp_d  [NUM_SRC]
);

    for (genvar i = 0; i < NUM_SRC; i++) begin : g_src
        logic hit;
        assign hit = (int'(idx) == i);

        always_comb begin
            pin_d[i] = (pin_we && hit) ? pin_wval : pin_q[i];
            map_d[i] = (vp_we && hit) ? vp_wmap : map_q[i];
            vp_d[i]  = (vp_we && hit) ? vp_wval : vp_q[i];
        end

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                pin_q[i] <= '0;
                map_q[i] <= 1'b0;
                vp_q[i]  <= '0;
            end else begin
                pin_q[i] <= pin_d[i];
                map_q[i] <= map_d[i];
                vp_q[i]  <= vp_d[i];
            end
        end

        // R8
        pin_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
            int'(pin_q[i]) < NUM_PIN);

        // R9
        vp_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
            map_q[i] |-> (int'(vp_q[i]) < NUM_VP));
    end

endmodule

// File: rtl/irq_pin_router.sv
module irq_pin_router #(
    parameter int NUM_SRC = 32,
    parameter int NUM_VP  = 2,
    parameter int NUM_PIN = 6,
    parameter int PIN_OFS = 2,
    localparam int VPW   = (NUM_VP > 1) ? $clog2(NUM_VP) : 1,
    localparam int PW    = (NUM_PIN > 1) ? $clog2(NUM_PIN) : 1,
    localparam int LINES = NUM_PIN + PIN_OFS
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic [NUM_SRC-1:0]      en_d,
    input  logic [NUM_SRC-1:0]      pend_d,
    input  logic                    map_d [NUM_SRC],
    input  logic [VPW-1:0]          vp_d  [NUM_SRC],
    input  logic [PW-1:0]           pin_d [NUM_SRC],
    output logic [NUM_VP*LINES-1:0] cpu_irq
);

    logic [NUM_VP*LINES-1:0] irq_nxt;

    always_comb begin
        irq_nxt = '0;
        for (int v = 0; v < NUM_VP; v++) begin
            for (int p = 0; p < NUM_PIN; p++) begin
                for (int s = 0; s < NUM_SRC; s++) begin
                    if (en_d[s] && pend_d[s] && map_d[s] &&
                        int'(vp_d[s]) == v && int'(pin_d[s]) == p)
                        irq_nxt[v*LINES + p + PIN_OFS] = 1'b1;
                end
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cpu_irq <= '0;
        else        cpu_irq <= irq_nxt;
    end

endmodule

// File: rtl/irq_source_router.sv
module irq_source_router
    import irq_route_pkg::*;
#(
    parameter int NUM_SRC = 32,
    parameter int NUM_VP  = 2,
    parameter int NUM_PIN = 6,
    parameter int PIN_OFS = 2
) (
    input  logic                                   clk,
    input  logic                                   rst_n,
    input  logic [NUM_SRC-1:0]                     src_in,
    input  logic [ADDR_W-1:0]                      bus_addr,
    input  logic                                   bus_we,
    input  logic [31:0]                            bus_wdata,
    output logic [31:0]                            bus_rdata,
    output logic [NUM_VP*(NUM_PIN+PIN_OFS)-1:0]    cpu_irq
);

    localparam int SW  = $clog2(NUM_SRC);
    localparam int VPW = (NUM_VP > 1) ? $clog2(NUM_VP) : 1;
    localparam int PW  = (NUM_PIN > 1) ? $clog2(NUM_PIN) : 1;
    localparam int EXT = MAX_SRC + 32;

    region_e           rg;
    logic [ADDR_W-1:0] off;
    logic [ADDR_W-1:0] src_full;
    int                bm_lo;
    logic              bm_ok;
    logic              map_ok;
    logic [SW-1:0]     map_idx;
    logic [EXT-1:0]    wide_wr;
    logic [EXT-1:0]    pend_ext;
    logic [EXT-1:0]    en_ext;
    logic [NUM_SRC-1:0] set_vec, clr_vec;
    logic              wedge_we;
    logic [5:0]        vp_lsb;
    logic              pin_we, vp_we;

    logic [NUM_SRC-1:0] en_q, pend_q, en_d, pend_d;
    logic [PW-1:0]      pin_q [NUM_SRC];
    logic               map_q [NUM_SRC];
    logic [VPW-1:0]     vp_q  [NUM_SRC];
    logic [PW-1:0]      pin_d [NUM_SRC];
    logic               map_d [NUM_SRC];
    logic [VPW-1:0]     vp_d  [NUM_SRC];

    always_comb begin
        rg  = RG_NONE;
        off = '0;
        if (bus_addr == A_CONFIG) rg = RG_CONFIG;
        else if (bus_addr == A_WEDGE) rg = RG_WEDGE;
        else if (bus_addr >= A_PEND && bus_addr < A_PEND + 14'd32) begin
            rg = RG_PEND;  off = bus_addr - A_PEND;
        end else if (bus_addr >= A_MASK && bus_addr < A_MASK + 14'd32) begin
            rg = RG_MASK;  off = bus_addr - A_MASK;
        end else if (bus_addr >= A_SETM && bus_addr < A_SETM + 14'd32) begin
            rg = RG_SETM;  off = bus_addr - A_SETM;
        end else if (bus_addr >= A_CLRM && bus_addr < A_CLRM + 14'd32) begin
            rg = RG_CLRM;  off = bus_addr - A_CLRM;
        end else if (bus_addr >= A_PINMAP && bus_addr < A_VPMAP) begin
            rg = RG_PINMAP; off = bus_addr - A_PINMAP;
        end else if (bus_addr >= A_VPMAP && bus_addr < A_VPEND) begin
            rg = RG_VPMAP;  off = bus_addr - A_VPMAP;
        end
    end

    assign bm_lo    = int'(off[4:0]) * 8;
    assign bm_ok    = (bm_lo + 32) <= NUM_SRC;
    assign src_full = (rg == RG_VPMAP) ? (off >> 5) : (off >> 2);
    assign map_ok   = int'(src_full) < NUM_SRC;
    assign map_idx  = src_full[SW-1:0];
    assign wide_wr  = {{(EXT-32){1'b0}}, bus_wdata} << bm_lo;
    assign pend_ext = {{(EXT-NUM_SRC){1'b0}}, pend_q};
    assign en_ext   = {{(EXT-NUM_SRC){1'b0}}, en_q};

    assign set_vec  = (bus_we && rg == RG_SETM && bm_ok) ? wide_wr[NUM_SRC-1:0] : '0;
    assign clr_vec  = (bus_we && rg == RG_CLRM && bm_ok) ? wide_wr[NUM_SRC-1:0] : '0;
    assign wedge_we = bus_we && rg == RG_WEDGE && (bus_wdata[30:0] < 31'(NUM_SRC));
    assign vp_lsb   = lowest_set(bus_wdata);
    assign pin_we   = bus_we && rg == RG_PINMAP && map_ok &&
                      (int'(bus_wdata[5:0]) < NUM_PIN);
    assign vp_we    = bus_we && rg == RG_VPMAP && map_ok &&
                      (bus_wdata == '0 || int'(vp_lsb) < NUM_VP);

    always_comb begin
        bus_rdata = '0;
        unique case (rg)
            RG_CONFIG: bus_rdata = {16'd0, 8'(NUM_SRC/8 - 1), 8'(NUM_VP)};
            RG_PEND:   if (bm_ok) bus_rdata = pend_ext[bm_lo +: 32];
            RG_MASK:   if (bm_ok) bus_rdata = en_ext[bm_lo +: 32];
            RG_PINMAP: if (map_ok) bus_rdata = {1'b1, 25'd0, 6'(pin_q[map_idx])};
            RG_VPMAP:  if (map_ok && map_q[map_idx])
                           bus_rdata = 32'd1 << vp_q[map_idx];
            RG_NONE, RG_WEDGE, RG_SETM, RG_CLRM: bus_rdata = '0;
            default:   bus_rdata = '0;
        endcase
    end

    irq_src_bank #(.NUM_SRC(NUM_SRC)) u_src (
        .clk(clk), .rst_n(rst_n), .src_in(src_in),
        .set_vec(set_vec), .clr_vec(clr_vec),
        .wedge_we(wedge_we), .wedge_idx(bus_wdata[SW-1:0]), .wedge_lvl(bus_wdata[31]),
        .en_q(en_q), .pend_q(pend_q), .en_d(en_d), .pend_d(pend_d)
    );

    irq_map_bank #(.NUM_SRC(NUM_SRC), .NUM_VP(NUM_VP), .NUM_PIN(NUM_PIN)) u_map (
        .clk(clk), .rst_n(rst_n), .pin_we(pin_we), .vp_we(vp_we), .idx(map_idx),
        .pin_wval(bus_wdata[PW-1:0]), .vp_wmap(|bus_wdata), .vp_wval(vp_lsb[VPW-1:0]),
        .pin_q(pin_q), .map_q(map_q), .vp_q(vp_q),
        .pin_d(pin_d), .map_d(map_d), .vp_d(vp_d)
    );

    irq_pin_router #(.NUM_SRC(NUM_SRC), .NUM_VP(NUM_VP), .NUM_PIN(NUM_PIN),
                     .PIN_OFS(PIN_OFS)) u_route (
        .clk(clk), .rst_n(rst_n), .en_d(en_d), .pend_d(pend_d),
        .map_d(map_d), .vp_d(vp_d), .pin_d(pin_d), .cpu_irq(cpu_irq)
    );

    // R4
    quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (en_q == '0) |-> (cpu_irq == '0));

    // R4
    pend_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((en_q & pend_q) == '0) |-> (cpu_irq == '0));

endmodule

// File: tb/tb_irq_source_router.sv
module tb_irq_source_router;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [31:0] src_in = '0;
    logic [13:0] bus_addr = '0;
    logic        bus_we = 1'b0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic [15:0] cpu_irq;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    always #10 clk = ~clk;

    irq_source_router dut (
        .clk(clk), .rst_n(rst_n), .src_in(src_in), .bus_addr(bus_addr),
        .bus_we(bus_we), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .cpu_irq(cpu_irq)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=0x%08h expected=0x%08h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [13:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_addr = a; bus_wdata = d; bus_we = 1'b1;
        @(negedge clk);
        bus_we = 1'b0;
    endtask

    task automatic rd(input logic [13:0] a, output logic [31:0] d);
        @(negedge clk);
        bus_addr = a; bus_we = 1'b0;
        #1 d = bus_rdata;
    endtask

    task automatic drive_src(input int i, input logic v);
        @(negedge clk);
        src_in[i] = v;
        @(negedge clk);
    endtask

    task automatic t_reset;
        logic [31:0] d;
        check("R1 irq", 32'(cpu_irq), 32'h0);
        rd(14'h100, d); check("R1 pend", d, 32'h0);
        rd(14'h120, d); check("R1 mask", d, 32'h0);
        rd(14'h404, d); check("R1 pinmap", d, 32'h80000000);
        rd(14'h820, d); check("R1 vpmap", d, 32'h0);
        rd(14'h000, d); check("R2 config", d, 32'h00000302);
    endtask

    task automatic t_pending;
        logic [31:0] d;
        drive_src(5, 1'b1);
        rd(14'h100, d); check("R3 pend rise", d, 32'h20);
        check("R4 disabled quiet", 32'(cpu_irq), 32'h0);
        drive_src(5, 1'b0);
        rd(14'h100, d); check("R3 pend fall", d, 32'h0);
    endtask

    task automatic t_route;
        logic [31:0] d;
        wr(14'h860, 32'h2); wr(14'h40C, 32'd4); wr(14'h140, 32'h08);
        wr(14'h8E0, 32'h2); wr(14'h41C, 32'd4); wr(14'h140, 32'h80);
        rd(14'h120, d); check("R5 set keeps others", d, 32'h88);
        drive_src(3, 1'b1);
        check("R4 route vp1 pin4", 32'(cpu_irq), 32'h4000);
        drive_src(7, 1'b1);
        check("R4 shared line", 32'(cpu_irq), 32'h4000);
        drive_src(3, 1'b0);
        check("R4 or remaining", 32'(cpu_irq), 32'h4000);
        drive_src(7, 1'b0);
        check("R4 all dropped", 32'(cpu_irq), 32'h0);
    endtask

    task automatic t_clear;
        logic [31:0] d;
        drive_src(3, 1'b1); drive_src(7, 1'b1);
        wr(14'h160, 32'h08);
        rd(14'h120, d); check("R5 clear one", d, 32'h80);
        check("R5 other still drives", 32'(cpu_irq), 32'h4000);
        wr(14'h160, 32'h80);
        check("R5 line off", 32'(cpu_irq), 32'h0);
        rd(14'h120, d); check("R5 mask empty", d, 32'h0);
    endtask

    task automatic t_offset;
        logic [31:0] d;
        wr(14'h141, 32'hFFFFFFFF);
        rd(14'h120, d); check("R6 past-end write ignored", d, 32'h0);
        rd(14'h100, d); check("R6 offset0 pend", d, 32'h88);
        rd(14'h101, d); check("R6 past-end read zero", d, 32'h0);
        drive_src(3, 1'b0); drive_src(7, 1'b0);
    endtask

    task automatic t_wedge;
        logic [31:0] d;
        wr(14'h004, 32'h80000009);
        rd(14'h100, d); check("R7 wedge raise", d, 32'h200);
        wr(14'h004, 32'h00000009);
        rd(14'h100, d); check("R7 wedge lower", d, 32'h0);
        wr(14'h004, 32'h80000020);
        rd(14'h100, d); check("R7 index out of range", d, 32'h0);
        wr(14'h920, 32'h1); wr(14'h424, 32'd0); wr(14'h140, 32'h200);
        wr(14'h004, 32'h80000009);
        check("R7 wedge drives vp0 pin0", 32'(cpu_irq), 32'h0004);
        wr(14'h920, 32'h0);
        check("R9 unassign drops line", 32'(cpu_irq), 32'h0);
        rd(14'h920, d); check("R9 unassigned reads 0", d, 32'h0);
    endtask

    task automatic t_maps;
        logic [31:0] d;
        wr(14'h40C, 32'd6);
        rd(14'h40C, d); check("R8 pin reject", d, 32'h80000004);
        wr(14'h40C, 32'd5);
        rd(14'h40C, d); check("R8 max pin accepted", d, 32'h80000005);
        wr(14'h860, 32'h4);
        rd(14'h860, d); check("R9 vp reject", d, 32'h2);
        wr(14'h860, 32'h5);
        rd(14'h860, d); check("R9 lowest bit vp0", d, 32'h1);
        wr(14'h874, 32'h6);
        rd(14'h860, d); check("R9 slot alias lowest bit vp1", d, 32'h2);
    endtask

    task automatic t_unmapped;
        logic [31:0] d;
        rd(14'h008, d); check("R10 hole", d, 32'h0);
        rd(14'h004, d); check("R10 wedge reads 0", d, 32'h0);
        wr(14'h4A0, 32'd3);
        rd(14'h4A0, d); check("R10 pinmap beyond count", d, 32'h0);
        wr(14'h008, 32'hFFFFFFFF);
        rd(14'h120, d); check("R10 hole write no effect", d, 32'h200);
    endtask

    initial begin
        #(20 * 100000);
        if (!done) begin
            errors++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_pending();
        t_route();
        t_clear();
        t_offset();
        t_wedge();
        t_maps();
        t_unmapped();
        done = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule